// File: doc/BRIEF.md
# Unaligned Doubleword Extract and Insert Unit

This unit is a one-stage registered datapath for a pair of naturally aligned 64-bit words that straddle an unaligned byte position. In extract mode the caller supplies the aligned word at the base address (the low word), the aligned word eight bytes above it (the high word) and the low three bits of a byte pointer. The unit returns the 64 bits that start at that byte position. This is the value a misaligned load would deliver after both aligned words have been fetched.

In insert mode the same pair of words and the same offset come with a 64-bit store value. The unit merges the store value into the two words at the byte position and returns both updated words. It also returns a per-byte write mask for each word, so that only the touched bytes need to be written back. A zero offset is a corner case in both modes. In extract mode the low word is passed through on a bypass path. In insert mode the high word is left untouched with an empty mask.

Top module: `dword_align_unit`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge, so each result appears exactly one cycle after its request.
- R2: While `rst` is high at a clock edge, every output is cleared to zero on that edge.
- R3: Byte j of a word occupies bits 8j+7:8j. In extract mode (`in_mode` = 0) with offset k in 1..7, `out_data` = (lo >> 8k) | (hi << (64 − 8k)).
- R4: In extract mode with offset 0, `out_data` equals the low word exactly, with no contribution from the high word.
- R5: In insert mode (`in_mode` = 1) with offset k, `out_lo` = (lo & ~(ones << 8k)) | (val << 8k).
- R6: In insert mode with offset k in 1..7, `out_hi` = (hi & ~(ones >> (64 − 8k))) | (val >> (64 − 8k)). With offset 0, `out_hi` equals the incoming high word.
- R7: In insert mode, bit j of `out_lo_be` is set exactly when j ≥ k, and bit j of `out_hi_be` is set exactly when j < k. Together the two masks cover exactly eight bytes.
- R8: In extract mode, `out_lo`, `out_hi`, `out_lo_be` and `out_hi_be` are zero. In insert mode, `out_data` is zero.
- R9: When `in_valid` is low, all data and mask outputs keep their previous values and the inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 1 | 0 = extract, 1 = insert |
| in_ofs | input | 3 | Low three bits of the byte pointer |
| in_lo | input | 64 | Aligned word at the base address |
| in_hi | input | 64 | Aligned word at base + 8 |
| in_val | input | 64 | Store value (insert mode) |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_mode | output | 1 | Mode of the registered result |
| out_data | output | 64 | Extracted doubleword |
| out_lo | output | 64 | Updated low word (insert) |
| out_hi | output | 64 | Updated high word (insert) |
| out_lo_be | output | 8 | Byte write mask for the low word |
| out_hi_be | output | 8 | Byte write mask for the high word |

## Verification
The hardest case to reach is the zero offset. Random offsets land on it only one time in eight, and a result taken from the wrong word can still agree with a careless model when both input words are equal. The stimulus therefore sweeps every offset in both modes with low and high words that differ in every byte. Random traffic with independently drawn words follows, and idle cycles with changing inputs are mixed in to show that the outputs hold.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
  typedef enum logic {
    MODE_EXTRACT = 1'b0,
    MODE_INSERT  = 1'b1
  } dwx_mode_e;
endpackage

// File: rtl/dwx_ofs_decode.sv
// Turns the byte offset into per-byte write masks and a zero-offset flag.
module dwx_ofs_decode #(
  parameter int NB    = 8,
  parameter int OFS_W = 3
) (
  input  logic [OFS_W-1:0] ofs,
  output logic             is_zero,
  output logic [NB-1:0]    lo_be,
  output logic [NB-1:0]    hi_be
);
  assign is_zero = (ofs == '0);

  for (genvar j = 0; j < NB; j++) begin : g_lane
    localparam logic [OFS_W:0] LANE = (OFS_W+1)'(j);
    assign lo_be[j] = (LANE >= {1'b0, ofs});
    assign hi_be[j] = (LANE <  {1'b0, ofs});
  end
endmodule

// File: rtl/dwx_extract.sv
// Byte funnel: result byte i is byte (i + ofs) of the pair {hi, lo}.
module dwx_extract #(
  parameter int NB    = 8,
  parameter int BW    = 8,
  parameter int OFS_W = 3
) (
  input  logic [NB*BW-1:0] lo,
  input  logic [NB*BW-1:0] hi,
  input  logic [OFS_W-1:0] ofs,
  input  logic             is_zero,
  output logic [NB*BW-1:0] data
);
  localparam int W = NB * BW;

  logic [2*W-1:0] pair;
  logic [W-1:0]   funnel;

  assign pair = {hi, lo};

  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_comb begin
      funnel[i*BW +: BW] = '0;
      for (int k = 0; k < NB; k++) begin
        if (ofs == OFS_W'(k)) funnel[i*BW +: BW] = pair[(i+k)*BW +: BW];
      end
    end
  end

  // Explicit bypass for the aligned case: no high-word contribution at all.
  assign data = is_zero ? lo : funnel;
endmodule

// File: rtl/dwx_insert.sv
// Places the store value at the byte offset across a double-width window,
// then merges it into each word under the byte masks.
module dwx_insert #(
  parameter int NB    = 8,
  parameter int BW    = 8,
  parameter int OFS_W = 3
) (
  input  logic [NB*BW-1:0] lo,
  input  logic [NB*BW-1:0] hi,
  input  logic [NB*BW-1:0] val,
  input  logic [OFS_W-1:0] ofs,
  input  logic [NB-1:0]    lo_be,
  input  logic [NB-1:0]    hi_be,
  output logic [NB*BW-1:0] new_lo,
  output logic [NB*BW-1:0] new_hi
);
  localparam int W = NB * BW;

  logic [2*W-1:0] placed;

  always_comb begin
    placed = '0;
    for (int k = 0; k < NB; k++) begin
      if (ofs == OFS_W'(k)) placed = {{W{1'b0}}, val} << (k * BW);
    end
  end

  for (genvar j = 0; j < NB; j++) begin : g_merge
    assign new_lo[j*BW +: BW] = lo_be[j] ? placed[j*BW +: BW]     : lo[j*BW +: BW];
    assign new_hi[j*BW +: BW] = hi_be[j] ? placed[W + j*BW +: BW] : hi[j*BW +: BW];
  end
endmodule

// File: rtl/dword_align_unit.sv
module dword_align_unit #(
  parameter int WORD_W = 64,
  parameter int BYTE_W = 8,
  localparam int NB    = WORD_W / BYTE_W,
  localparam int OFS_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic [OFS_W-1:0]  in_ofs,
  input  logic [WORD_W-1:0] in_lo,
  input  logic [WORD_W-1:0] in_hi,
  input  logic [WORD_W-1:0] in_val,
  output logic              out_valid,
  output logic              out_mode,
  output logic [WORD_W-1:0] out_data,
  output logic [WORD_W-1:0] out_lo,
  output logic [WORD_W-1:0] out_hi,
  output logic [NB-1:0]     out_lo_be,
  output logic [NB-1:0]     out_hi_be
);
  import dwx_pkg::*;

  dwx_mode_e         mode;
  logic              ofs_zero;
  logic [NB-1:0]     be_lo, be_hi;
  logic [WORD_W-1:0] ext_data, ins_lo, ins_hi;

  assign mode = dwx_mode_e'(in_mode);

  dwx_ofs_decode #(.NB(NB), .OFS_W(OFS_W)) u_dec (
    .ofs(in_ofs), .is_zero(ofs_zero), .lo_be(be_lo), .hi_be(be_hi)
  );

  dwx_extract #(.NB(NB), .BW(BYTE_W), .OFS_W(OFS_W)) u_ext (
    .lo(in_lo), .hi(in_hi), .ofs(in_ofs), .is_zero(ofs_zero), .data(ext_data)
  );

  dwx_insert #(.NB(NB), .BW(BYTE_W), .OFS_W(OFS_W)) u_ins (
    .lo(in_lo), .hi(in_hi), .val(in_val), .ofs(in_ofs),
    .lo_be(be_lo), .hi_be(be_hi), .new_lo(ins_lo), .new_hi(ins_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mode  <= 1'b0;
      out_data  <= '0;
      out_lo    <= '0;
      out_hi    <= '0;
      out_lo_be <= '0;
      out_hi_be <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mode <= in_mode;
        if (mode == MODE_INSERT) begin
          out_data  <= '0;
          out_lo    <= ins_lo;
          out_hi    <= ins_hi;
          out_lo_be <= be_lo;
          out_hi_be <= be_hi;
        end else begin
          out_data  <= ext_data;
          out_lo    <= '0;
          out_hi    <= '0;
          out_lo_be <= '0;
          out_hi_be <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/dwx_align_chk.sv
module dwx_align_chk #(
  parameter int WORD_W = 64,
  parameter int BYTE_W = 8,
  localparam int NB    = WORD_W / BYTE_W,
  localparam int OFS_W = $clog2(NB)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_mode,
  input logic [OFS_W-1:0]  in_ofs,
  input logic [WORD_W-1:0] in_lo,
  input logic [WORD_W-1:0] in_hi,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data,
  input logic [WORD_W-1:0] out_lo,
  input logic [WORD_W-1:0] out_hi,
  input logic [NB-1:0]     out_lo_be,
  input logic [NB-1:0]     out_hi_be
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_ZERO_OFS_EXTRACT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_mode && in_ofs == '0) |=> (out_data == $past(in_lo))); // R4
  AST_ZERO_OFS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode && in_ofs == '0) |=> (out_hi == $past(in_hi) && out_hi_be == '0)); // R6
  AST_MASK_PARTITION: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode) |=> ((out_lo_be & out_hi_be) == '0 &&
      ($countones(out_lo_be) + $countones(out_hi_be)) == NB)); // R7
  AST_EXTRACT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_mode) |=> (out_lo == '0 && out_hi == '0 && out_lo_be == '0)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> ($stable(out_data) && $stable(out_lo) && $stable(out_hi))); // R9
endmodule

bind dword_align_unit dwx_align_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode), .in_ofs(in_ofs),
  .in_lo(in_lo), .in_hi(in_hi), .out_valid(out_valid), .out_data(out_data),
  .out_lo(out_lo), .out_hi(out_hi), .out_lo_be(out_lo_be), .out_hi_be(out_hi_be)
);

// File: tb/dword_align_unit_test.sv
module dword_align_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_mode;
  logic [2:0]  in_ofs;
  logic [63:0] in_lo, in_hi, in_val;
  logic        out_valid, out_mode;
  logic [63:0] out_data, out_lo, out_hi;
  logic [7:0]  out_lo_be, out_hi_be;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dword_align_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode), .in_ofs(in_ofs),
    .in_lo(in_lo), .in_hi(in_hi), .in_val(in_val), .out_valid(out_valid),
    .out_mode(out_mode), .out_data(out_data), .out_lo(out_lo), .out_hi(out_hi),
    .out_lo_be(out_lo_be), .out_hi_be(out_hi_be)
  );

  function automatic logic [63:0] ref_extract(logic [63:0] lo, logic [63:0] hi, int k);
    if (k == 0) return lo;
    return (lo >> (8*k)) | (hi << (64 - 8*k));
  endfunction

  function automatic logic [63:0] ref_ins_lo(logic [63:0] lo, logic [63:0] v, int k);
    logic [63:0] ones = '1;
    return (lo & ~(ones << (8*k))) | (v << (8*k));
  endfunction

  function automatic logic [63:0] ref_ins_hi(logic [63:0] hi, logic [63:0] v, int k);
    logic [63:0] ones = '1;
    if (k == 0) return hi;
    return (hi & ~(ones >> (64 - 8*k))) | (v >> (64 - 8*k));
  endfunction

  function automatic logic [7:0] ref_lo_be(int k);
    logic [7:0] m = '0;
    for (int j = 0; j < 8; j++) m[j] = (j >= k);
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic mode, logic [63:0] lo, logic [63:0] hi, logic [63:0] v, int k);
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_ofs = 3'(k);
    in_lo = lo; in_hi = hi; in_val = v;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 valid", {63'b0, out_valid}, 64'd1);
    if (!mode) begin
      chk(k == 0 ? "R4 extract zero ofs" : "R3 extract", out_data, ref_extract(lo, hi, k));
      chk("R8 extract quiet", out_lo | out_hi | {48'b0, out_lo_be, out_hi_be}, 64'd0);
    end else begin
      chk("R5 insert lo", out_lo, ref_ins_lo(lo, v, k));
      chk("R6 insert hi", out_hi, ref_ins_hi(hi, v, k));
      chk("R7 lo mask", {56'b0, out_lo_be}, {56'b0, ref_lo_be(k)});
      chk("R7 hi mask", {56'b0, out_hi_be}, {56'b0, ~ref_lo_be(k)});
      chk("R8 insert data zero", out_data, 64'd0);
    end
  endtask

  task automatic idle_hold();
    logic [63:0] d, l, h;
    d = out_data; l = out_lo; h = out_hi;
    in_mode = ~in_mode; in_ofs = in_ofs + 3'd3;
    in_lo = {$urandom, $urandom}; in_hi = ~in_lo; in_val = {$urandom, $urandom};
    @(negedge clk);
    chk("R1 idle valid", {63'b0, out_valid}, 64'd0);
    chk("R9 hold data", out_data, d);
    chk("R9 hold lo", out_lo, l);
    chk("R9 hold hi", out_hi, h);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; in_valid = 1'b1; in_mode = 1'b1; in_ofs = 3'd5;
    in_lo = '1; in_hi = '1; in_val = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset valid", {63'b0, out_valid}, 64'd0);
    chk("R2 reset data", out_data | out_lo | out_hi, 64'd0);
    chk("R2 reset masks", {48'b0, out_lo_be, out_hi_be}, 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // Directed sweep: every offset, both modes, words differing in every byte.
    for (int k = 0; k < 8; k++) begin
      run_op(1'b0, 64'h0706050403020100, 64'hF7F6F5F4F3F2F1F0, 64'h0, k);
      run_op(1'b1, 64'h1111111111111111, 64'h2222222222222222, 64'hA7A6A5A4A3A2A1A0, k);
    end
    run_op(1'b0, 64'h0, 64'hFFFFFFFFFFFFFFFF, 64'h0, 0);   // R4: no high leak
    run_op(1'b0, 64'h0, 64'hFFFFFFFFFFFFFFFF, 64'h0, 7);   // R3 extreme
    run_op(1'b1, 64'h0, 64'h0, 64'hFFFFFFFFFFFFFFFF, 0);   // R6 high untouched
    idle_hold();

    for (int n = 0; n < 400; n++) begin
      run_op(1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
             {$urandom, $urandom}, int'($urandom % 8));
      if (($urandom % 5) == 0) idle_hold();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule